// File: doc/BRIEF.md
# Byte-Wide Flash Erase, Program and Verify Sequencer

This block drives a device programmer through one complete pass over a byte-wide, electrically erasable memory. When `start` is seen, it turns on the program supply and the address-line supervoltage together. It then gives a single timed erase strobe, drops both high voltages, and waits out the recovery time. Next it reads every location and checks that each one holds the erased value FFh. If that blank check succeeds, it programs the whole array in ascending address order. Each byte gets one timed strobe, with address, data and program supply held stable for a setup window before the strobe and a hold window after it. Finally it removes the program supply, waits for recovery again, and reads the whole device back against the image.

The bytes to write come from a local image buffer through an asynchronous read port that shares the sequencer's address. Every duration is a parameter counted in clock cycles. The block stops at the first miscompare in either read pass, records the failing address and raises `fail`. A clean run ends with `pass`. An abort input drops every high-voltage enable at the next clock edge. The analog supply switches sit outside this block; it only drives their digital enables.

Top module: `prom_burn_seq`

## Requirements
- R1: While reset is held and after its release, `busy`, `pass`, `fail`, `prog_supply_en`, `addr_hv_en`, `dev_strobe`, `dev_oe` and `dev_wdata_oe` are all 0.
- R2: The erase phase raises `prog_supply_en` and `addr_hv_en` together. They stay stable for SETUP_CYC cycles, and then exactly one `dev_strobe` pulse of ERASE_CYC cycles is given. `addr_hv_en` is never 1 while `prog_supply_en` is 0.
- R3: After any strobe, the high voltages stay on for HOLD_CYC cycles. Both are then off for at least RECOV_CYC cycles before `dev_oe` rises, and `dev_oe` is never 1 while a high voltage is on.
- R4: The blank check reads every address from 0 upward, each for ACCESS_CYC cycles. At the first address whose data is not FFh, it stops with `fail`=1 and `fail_addr` equal to that address, and no byte is programmed.
- R5: Each program strobe lasts PROG_CYC cycles with `prog_supply_en`=1 and `addr_hv_en`=0. `dev_addr`, `dev_wdata` and both enables are stable for SETUP_CYC cycles before it, throughout it, and for HOLD_CYC cycles after it. `dev_wdata` equals the image byte at `dev_addr`.
- R6: Every address from 0 to 2^ADDR_W-1 receives exactly one program strobe, in ascending order.
- R7: After the last byte, the program supply is removed, the recovery wait passes, and each byte is read and compared with the image byte. At the first mismatch the block stops with `fail`=1 and `fail_addr` equal to that address.
- R8: A clean run ends with `pass`=1. `busy` is high for exactly SETUP+ERASE+HOLD+RECOV + D·ACCESS + D·(SETUP+PROG+HOLD) + RECOV + D·ACCESS cycles, with D = 2^ADDR_W. At most one of `busy`, `pass` and `fail` is 1.
- R9: `abort`=1 at a clock edge turns off `prog_supply_en`, `addr_hv_en`, `dev_strobe` and `dev_wdata_oe` at that same edge and returns the block to idle with `busy`, `pass` and `fail` all 0.
- R10: `dev_strobe` and `dev_oe` are never 1 together, and `dev_wdata_oe` is 1 only while `prog_supply_en` is 1 and `addr_hv_en` is 0.
- R11: `start` while idle, passed or failed clears `pass`, `fail` and `fail_addr` and sets `busy` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a full erase, blank check, program and verify run |
| abort | input | 1 | Stop at once and switch off all high voltages |
| img_addr | output | ADDR_W | Image buffer read address |
| img_rd_data | input | 8 | Image byte at `img_addr`, asynchronous read |
| dev_addr | output | ADDR_W | Address driven to the target device |
| dev_wdata | output | 8 | Byte driven onto the device data bus |
| dev_wdata_oe | output | 1 | Drive enable for the device data bus |
| dev_rdata | input | 8 | Byte read from the device data bus |
| dev_strobe | output | 1 | Erase or program strobe, active high |
| dev_oe | output | 1 | Device read enable, active high |
| prog_supply_en | output | 1 | Enable for the program supply switch |
| addr_hv_en | output | 1 | Enable for the address-line supervoltage switch |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run completed with no miscompare |
| fail | output | 1 | Last run stopped on a miscompare |
| fail_addr | output | ADDR_W | Address of the miscompare |

## Verification
All outputs are registered from the next-state value, so each output reacts one clock edge after the input that causes it. `busy` rises at the edge that samples `start`, and the abort result shows at the edge that samples `abort`. Each phase then lasts exactly its parameter count, so the bench predicts the length of the busy window from the phase durations and the failing address, and compares the measured window against that prediction. A monitor that samples on the falling clock edge counts stable cycles before each strobe, strobe width, hold cycles after it, and high-voltage-off cycles before each read. It compares these counts with the parameters at the cycle the strobe or the read enable changes.

// File: rtl/burn_pkg.sv
// Package: shared state encoding and data constants for the erase/program sequencer.
// Assumes a byte-wide target device whose erased state reads as all ones.
package burn_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_E_SETUP,
        ST_E_PULSE,
        ST_E_HOLD,
        ST_E_RECOV,
        ST_BLANK,
        ST_P_SETUP,
        ST_P_PULSE,
        ST_P_HOLD,
        ST_P_RECOV,
        ST_VERIFY,
        ST_PASS,
        ST_FAIL
    } burn_state_e;
endpackage

// File: rtl/burn_timer.sv
// Module: down-counting phase timer.
// A load of length N makes `expired` high in the N-th cycle after the load edge,
// so the state that issued the load lasts exactly N cycles. Assumes N >= 1.
module burn_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count down from len-1 after a load, resting at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2
    long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len > 1) |=> !expired);
endmodule

// File: rtl/burn_addr_ctr.sv
// Module: address counter for the blank check, program and verify sweeps.
// Clears to zero and steps upward by one; `last` flags the top address.
module burn_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] addr_q;

    // Hold, clear or advance the sweep address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (clr)
            addr_q <= '0;
        else if (inc)
            addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
    assign last = &addr_q;

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !last) |=> (addr > $past(addr)));
endmodule

// File: rtl/burn_ctrl.sv
// Module: sequencing state machine for erase, blank check, program and verify.
// Drives timer loads and address-counter steps, compares read data, and
// registers all device-side enables from the next state so that the
// high-voltage enables are glitch-free and drop one edge after abort.
// Assumes the image read port returns data in the same cycle as its address.
module burn_ctrl
    import burn_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 24,
    parameter int SETUP_CYC  = 50,
    parameter int HOLD_CYC   = 50,
    parameter int ERASE_CYC  = 5000000,
    parameter int PROG_CYC   = 1000,
    parameter int RECOV_CYC  = 50,
    parameter int ACCESS_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tmr_exp,
    input  logic              addr_last,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] dev_rdata,
    input  logic [BYTE_W-1:0] img_rd_data,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_len,
    output logic              ctr_clr,
    output logic              ctr_inc,
    output logic              prog_supply_en,
    output logic              addr_hv_en,
    output logic              dev_strobe,
    output logic              dev_oe,
    output logic              dev_wdata_oe,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam logic [CNT_W-1:0] LEN_SETUP  = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] LEN_HOLD   = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] LEN_ERASE  = CNT_W'(ERASE_CYC);
    localparam logic [CNT_W-1:0] LEN_PROG   = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] LEN_RECOV  = CNT_W'(RECOV_CYC);
    localparam logic [CNT_W-1:0] LEN_ACCESS = CNT_W'(ACCESS_CYC);

    burn_state_e state_q, state_d;
    logic        at_rest;
    logic        launch;
    logic        miss_hit;
    logic        blank_bad;
    logic        verify_bad;

    assign at_rest    = (state_q == ST_IDLE) || (state_q == ST_PASS) || (state_q == ST_FAIL);
    assign launch     = at_rest && start && !abort;
    assign blank_bad  = (dev_rdata != ERASED_BYTE);
    assign verify_bad = (dev_rdata != img_rd_data);

    // Next-state, timer-load and address-step decisions for each phase.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        miss_hit = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start) begin
                    state_d  = ST_E_SETUP;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_SETUP;
                    ctr_clr  = 1'b1;
                end
            end
            ST_E_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_E_PULSE;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_ERASE;
                end
            end
            ST_E_PULSE: begin
                if (tmr_exp) begin
                    state_d  = ST_E_HOLD;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_HOLD;
                end
            end
            ST_E_HOLD: begin
                if (tmr_exp) begin
                    state_d  = ST_E_RECOV;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_RECOV;
                end
            end
            ST_E_RECOV: begin
                if (tmr_exp) begin
                    state_d  = ST_BLANK;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_ACCESS;
                    ctr_clr  = 1'b1;
                end
            end
            ST_BLANK: begin
                if (tmr_exp) begin
                    if (blank_bad) begin
                        state_d  = ST_FAIL;
                        miss_hit = 1'b1;
                    end else if (addr_last) begin
                        state_d  = ST_P_SETUP;
                        tmr_load = 1'b1;
                        tmr_len  = LEN_SETUP;
                        ctr_clr  = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_len  = LEN_ACCESS;
                        ctr_inc  = 1'b1;
                    end
                end
            end
            ST_P_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_P_PULSE;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_PROG;
                end
            end
            ST_P_PULSE: begin
                if (tmr_exp) begin
                    state_d  = ST_P_HOLD;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_HOLD;
                end
            end
            ST_P_HOLD: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (addr_last) begin
                        state_d = ST_P_RECOV;
                        tmr_len = LEN_RECOV;
                    end else begin
                        state_d = ST_P_SETUP;
                        tmr_len = LEN_SETUP;
                        ctr_inc = 1'b1;
                    end
                end
            end
            ST_P_RECOV: begin
                if (tmr_exp) begin
                    state_d  = ST_VERIFY;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_ACCESS;
                    ctr_clr  = 1'b1;
                end
            end
            ST_VERIFY: begin
                if (tmr_exp) begin
                    if (verify_bad) begin
                        state_d  = ST_FAIL;
                        miss_hit = 1'b1;
                    end else if (addr_last) begin
                        state_d = ST_PASS;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_len  = LEN_ACCESS;
                        ctr_inc  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d  = ST_IDLE;
            tmr_load = 1'b0;
            ctr_clr  = 1'b0;
            ctr_inc  = 1'b0;
            miss_hit = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Device-side enables and status, registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_supply_en <= 1'b0;
            addr_hv_en     <= 1'b0;
            dev_strobe     <= 1'b0;
            dev_oe         <= 1'b0;
            dev_wdata_oe   <= 1'b0;
            busy           <= 1'b0;
            pass           <= 1'b0;
            fail           <= 1'b0;
        end else begin
            prog_supply_en <= state_d inside {ST_E_SETUP, ST_E_PULSE, ST_E_HOLD,
                                              ST_P_SETUP, ST_P_PULSE, ST_P_HOLD};
            addr_hv_en     <= state_d inside {ST_E_SETUP, ST_E_PULSE, ST_E_HOLD};
            dev_strobe     <= state_d inside {ST_E_PULSE, ST_P_PULSE};
            dev_oe         <= state_d inside {ST_BLANK, ST_VERIFY};
            dev_wdata_oe   <= state_d inside {ST_P_SETUP, ST_P_PULSE, ST_P_HOLD};
            busy           <= !(state_d inside {ST_IDLE, ST_PASS, ST_FAIL});
            pass           <= (state_d == ST_PASS);
            fail           <= (state_d == ST_FAIL);
        end
    end

    // Capture the first miscompare address; cleared when a new run begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_addr <= '0;
        else if (launch)
            fail_addr <= '0;
        else if (miss_hit)
            fail_addr <= addr;
    end

    // R2
    hv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hv_en |-> prog_supply_en);
    // R3
    read_hv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_oe |-> (!prog_supply_en && !addr_hv_en));
    // R5
    pulse_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_strobe && $past(dev_strobe)) |-> $stable(addr));
    // R8
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, pass, fail}));
    // R9
    abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!prog_supply_en && !addr_hv_en && !dev_strobe && !busy));
    // R10
    strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_strobe && dev_oe));
    // R10
    drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wdata_oe |-> (prog_supply_en && !addr_hv_en));
    // R11
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !pass && !fail));
endmodule

// File: rtl/prom_burn_seq.sv
// Module: top of the erase, blank-check, program and verify sequencer.
// Wires the phase timer, the sweep address counter and the control FSM.
// Assumes: image port is asynchronous read; every cycle parameter >= 1;
// the device data bus is returned on dev_rdata while dev_oe is high.
module prom_burn_seq
    import burn_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SETUP_CYC  = 50,
    parameter int HOLD_CYC   = 50,
    parameter int ERASE_CYC  = 5000000,
    parameter int PROG_CYC   = 1000,
    parameter int RECOV_CYC  = 50,
    parameter int ACCESS_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    output logic [ADDR_W-1:0] img_addr,
    input  logic [7:0]        img_rd_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [7:0]        dev_wdata,
    output logic              dev_wdata_oe,
    input  logic [7:0]        dev_rdata,
    output logic              dev_strobe,
    output logic              dev_oe,
    output logic              prog_supply_en,
    output logic              addr_hv_en,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int MAX_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_B = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_C = (RECOV_CYC > ACCESS_CYC) ? RECOV_CYC : ACCESS_CYC;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN = (MAX_D > MAX_C) ? MAX_D : MAX_C;
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_exp;
    logic              ctr_clr;
    logic              ctr_inc;
    logic [ADDR_W-1:0] sweep_addr;
    logic              sweep_last;

    burn_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_exp)
    );

    burn_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .addr  (sweep_addr),
        .last  (sweep_last)
    );

    burn_ctrl #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ERASE_CYC  (ERASE_CYC),
        .PROG_CYC   (PROG_CYC),
        .RECOV_CYC  (RECOV_CYC),
        .ACCESS_CYC (ACCESS_CYC)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .abort          (abort),
        .tmr_exp        (tmr_exp),
        .addr_last      (sweep_last),
        .addr           (sweep_addr),
        .dev_rdata      (dev_rdata),
        .img_rd_data    (img_rd_data),
        .tmr_load       (tmr_load),
        .tmr_len        (tmr_len),
        .ctr_clr        (ctr_clr),
        .ctr_inc        (ctr_inc),
        .prog_supply_en (prog_supply_en),
        .addr_hv_en     (addr_hv_en),
        .dev_strobe     (dev_strobe),
        .dev_oe         (dev_oe),
        .dev_wdata_oe   (dev_wdata_oe),
        .busy           (busy),
        .pass           (pass),
        .fail           (fail),
        .fail_addr      (fail_addr)
    );

    assign img_addr  = sweep_addr;
    assign dev_addr  = sweep_addr;
    assign dev_wdata = dev_wdata_oe ? img_rd_data : '0;
endmodule

// File: tb/prom_burn_seq_test.sv
module prom_burn_seq_test;
    localparam int AW  = 4;
    localparam int D   = 1 << AW;
    localparam int TSU = 3;
    localparam int THD = 2;
    localparam int TER = 20;
    localparam int TPR = 6;
    localparam int TRC = 4;
    localparam int TAC = 2;
    localparam int ERASE_PART = TSU + TER + THD + TRC;

    // Vector: [15:14] image pattern, [13:12] fault kind (0 none, 1 bit3 stuck at 0,
    // 2 bit3 stuck at 1), [11:8] fault address, [7] pass expected, [3:0] fail address.
    localparam logic [15:0] VEC [8] = '{
        16'h0080, 16'h4080, 16'hD505, 16'h6909,
        16'hA980, 16'h1F0F, 16'hD000, 16'h2202
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic abort = 1'b0;
    logic [AW-1:0] img_addr, dev_addr, fail_addr;
    logic [7:0] img_rd_data, dev_wdata, dev_rdata;
    logic dev_wdata_oe, dev_strobe, dev_oe, prog_supply_en, addr_hv_en, busy, pass, fail;

    logic [7:0] img [D];
    logic [7:0] mem [D];
    logic [1:0] fault_kind;
    logic [AW-1:0] fault_addr;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // monitor state
    int stable_cnt, pulse_len, hold_cnt, off_cnt, busy_cnt;
    int su_viol, pw_viol, hold_viol, rec_viol, excl_viol, order_viol;
    int erase_pulses, prog_pulses;
    bit in_hold;
    logic [AW-1:0] next_addr;
    logic [AW+9:0] prev_bus;
    logic p_strobe, p_oe, p_hv;

    always #10 clk = ~clk;

    prom_burn_seq #(
        .ADDR_W(AW), .SETUP_CYC(TSU), .HOLD_CYC(THD), .ERASE_CYC(TER),
        .PROG_CYC(TPR), .RECOV_CYC(TRC), .ACCESS_CYC(TAC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .img_addr(img_addr), .img_rd_data(img_rd_data),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe),
        .dev_rdata(dev_rdata), .dev_strobe(dev_strobe), .dev_oe(dev_oe),
        .prog_supply_en(prog_supply_en), .addr_hv_en(addr_hv_en),
        .busy(busy), .pass(pass), .fail(fail), .fail_addr(fail_addr)
    );

    assign img_rd_data = img[img_addr];
    assign dev_rdata   = dev_oe ? mem[dev_addr] : 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_val(input logic [1:0] p, input int a);
        case (p)
            2'd0: pat_val = 8'(a * 7 + 3);
            2'd1: pat_val = 8'h00;
            2'd2: pat_val = 8'hFF;
            default: pat_val = 8'(a) ^ 8'h5A;
        endcase
    endfunction

    // Device model and protocol monitor, sampled away from the active edge.
    always @(negedge clk) begin
        logic [AW+9:0] cur;
        cyc++;
        cur = {dev_addr, dev_wdata, prog_supply_en, addr_hv_en};
        if (busy) busy_cnt++;
        if (cur == prev_bus) stable_cnt++; else stable_cnt = 0;
        if (dev_strobe && dev_oe) excl_viol++;
        if (dev_wdata_oe && (!prog_supply_en || addr_hv_en)) excl_viol++;
        if (dev_oe && !p_oe && off_cnt < TRC) rec_viol++;
        if (dev_strobe && !p_strobe) begin
            if (stable_cnt < TSU) su_viol++;
            pulse_len = 1;
            in_hold = 1'b0;
            if (addr_hv_en && prog_supply_en) begin
                erase_pulses++;
                for (int i = 0; i < D; i++) mem[i] = 8'hFF;
                if (fault_kind == 2'd1) mem[fault_addr][3] = 1'b0;
            end else if (prog_supply_en) begin
                prog_pulses++;
                if (dev_addr != next_addr) order_viol++;
                next_addr = dev_addr + 1'b1;
                mem[dev_addr] = mem[dev_addr] & dev_wdata;
                if (fault_kind == 2'd2 && dev_addr == fault_addr) mem[fault_addr][3] = 1'b1;
            end
        end else if (dev_strobe) begin
            pulse_len++;
            if (cur != prev_bus) su_viol++;
        end else if (p_strobe) begin
            if (pulse_len != (p_hv ? TER : TPR)) pw_viol++;
            hold_cnt = 1;
            in_hold = 1'b1;
            if (cur != prev_bus) hold_viol++;
        end else if (in_hold) begin
            if (cur != prev_bus) begin
                if (hold_cnt < THD) hold_viol++;
                in_hold = 1'b0;
            end else hold_cnt++;
        end
        if (!prog_supply_en && !addr_hv_en) off_cnt++; else off_cnt = 0;
        prev_bus = cur;
        p_strobe = dev_strobe;
        p_oe = dev_oe;
        p_hv = addr_hv_en;
        if (cyc > 150000 && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic clear_mon();
        busy_cnt = 0; su_viol = 0; pw_viol = 0; hold_viol = 0; rec_viol = 0;
        excl_viol = 0; order_viol = 0; erase_pulses = 0; prog_pulses = 0;
        next_addr = '0; in_hold = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk("watchdog busy", 32'(n), 0);
    endtask

    task automatic run_vec(input logic [15:0] v);
        logic [1:0] pat;
        logic exp_pass;
        logic [AW-1:0] efa;
        int exp_len, bad;
        pat = v[15:14];
        fault_kind = v[13:12];
        fault_addr = v[11:8];
        exp_pass = v[7];
        efa = v[3:0];
        for (int i = 0; i < D; i++) begin
            img[i] = pat_val(pat, i);
            mem[i] = ~img[i];
        end
        clear_mon();
        pulse_start();
        wait_idle();
        if (exp_pass)
            exp_len = ERASE_PART + D * TAC + D * (TSU + TPR + THD) + TRC + D * TAC;
        else if (fault_kind == 2'd1)
            exp_len = ERASE_PART + (int'(efa) + 1) * TAC;
        else
            exp_len = ERASE_PART + D * TAC + D * (TSU + TPR + THD) + TRC + (int'(efa) + 1) * TAC;
        chk("R8 pass flag", 32'(pass), 32'(exp_pass));
        chk("R4/R7 fail flag", 32'(fail), 32'(!exp_pass));
        chk("R8 busy length", 32'(busy_cnt), 32'(exp_len));
        chk("R2 erase pulse count", 32'(erase_pulses), 1);
        chk("R2/R5 setup and width", 32'(su_viol + pw_viol), 0);
        chk("R3 hold and recovery", 32'(hold_viol + rec_viol), 0);
        chk("R10 exclusion", 32'(excl_viol), 0);
        if (!exp_pass) chk("R4/R7 fail address", 32'(fail_addr), 32'(efa));
        if (fault_kind == 2'd1) chk("R4 no program after blank fail", 32'(prog_pulses), 0);
        else begin
            chk("R6 one strobe per byte", 32'(prog_pulses), 32'(D));
            chk("R6 ascending order", 32'(order_viol), 0);
        end
        if (exp_pass) begin
            bad = 0;
            for (int i = 0; i < D; i++) if (mem[i] != img[i]) bad++;
            chk("R5 device equals image", 32'(bad), 0);
        end
    endtask

    initial begin
        fault_kind = 2'd0;
        fault_addr = '0;
        prev_bus = '0; p_strobe = 0; p_oe = 0; p_hv = 0;
        stable_cnt = 0; off_cnt = 0; pulse_len = 0; hold_cnt = 0;
        clear_mon();
        for (int i = 0; i < D; i++) begin img[i] = 8'h00; mem[i] = 8'h00; end
        repeat (4) @(negedge clk);
        chk("R1 reset held outputs",
            32'({busy, pass, fail, prog_supply_en, addr_hv_en, dev_strobe, dev_oe, dev_wdata_oe}), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after release outputs",
            32'({busy, pass, fail, prog_supply_en, addr_hv_en, dev_strobe, dev_oe, dev_wdata_oe}), 0);

        for (int k = 0; k < 8; k++) run_vec(VEC[k]);

        // R11: restart from a failed result clears status at the next edge.
        chk("R11 fail held before restart", 32'(fail), 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R11 restart busy", 32'(busy), 1);
        chk("R11 restart clears results", 32'({pass, fail}), 0);
        chk("R11 restart clears fail address", 32'(fail_addr), 0);

        // R9: abort during erase supervoltage.
        while (!(prog_supply_en && addr_hv_en)) @(negedge clk);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk("R9 abort in erase enables off",
            32'({prog_supply_en, addr_hv_en, dev_strobe, dev_wdata_oe}), 0);
        chk("R9 abort in erase status", 32'({busy, pass, fail}), 0);

        // R9: abort during a program strobe.
        fault_kind = 2'd0;
        for (int i = 0; i < D; i++) img[i] = 8'h3C;
        pulse_start();
        while (!(dev_strobe && !addr_hv_en)) @(negedge clk);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk("R9 abort in program enables off",
            32'({prog_supply_en, addr_hv_en, dev_strobe, dev_wdata_oe}), 0);
        chk("R9 abort in program status", 32'({busy, pass, fail}), 0);
        repeat (3) @(negedge clk);
        chk("R9 stays idle after abort", 32'({busy, prog_supply_en, addr_hv_en}), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule